// File: doc/BRIEF.md
# Imprecise Error Pending Controller

This block keeps the pending state of four imprecise error sources (instruction-fetch bus error, data-access bus error, cache error and machine check) inside a debug control register word. It gates them with an inhibit bit. A hardware error pulse or a software write of 1 marks a source pending. The block asks the core for one exception at a time, and only while the inhibit bit is clear. A flag is dropped only when the core acknowledges that the requested exception was taken.

The inhibit bit rises whenever a debug exception is taken or an exception occurs in debug mode. It falls on a debug return. Debug-mode software may also write it directly. While the bit is set, every pending error is held back. When it clears with flags still set, the highest-priority pending source is requested at once.

The machine-check and cache-error sources can be removed by parameter. In that case they read 0 and never request. Both are removed by default.

Top module: `imperr_pend_ctrl`

## Requirements
- R1: After reset all four pending flags and the inhibit bit are 0. `rd_data` reads 0x0200_0000 and `exc_req` is 0.
- R2: The `rd_data` layout is as follows. Bit 25 always reads 1. Bit 24 is the instruction bus error flag and bit 23 the machine check flag. Bit 22 is the cache error flag and bit 21 the data bus error flag. Bit 20 is the inhibit bit. Every other bit reads 0, whatever is written.
- R3: An event pulse on a source sets its flag. The flag is visible on `rd_data` in the cycle after the clock edge that sampled the pulse.
- R4: A write with a 1 in a flag's bit position sets that flag. A 0 in that position leaves the flag unchanged.
- R5: A flag clears only at an edge where `ack` is high and `exc_req` presents that flag's source. If `ack` is high with no request, nothing changes. An event on the same source in the same cycle as its acknowledge keeps the flag set.
- R6: While the inhibit bit is 1, `exc_req` is 0 and all flags are retained.
- R7: While the inhibit bit is 0 and any flag is set, `exc_req` is one-hot. Its bits are machine check on bit 3, cache error on bit 2, instruction bus error on bit 1 and data bus error on bit 0. The highest set bit wins.
- R8: `dbg_entry` sets the inhibit bit and `dbg_ret` clears it. `dbg_entry` wins over `dbg_ret`. Both win over a register write.
- R9: A write of bit 20 updates the inhibit bit only when `in_debug` is high. Otherwise the bit keeps its value.
- R10: A source disabled by parameter (`EN_MCHK`=0 or `EN_CACHE`=0) ignores events and writes, reads 0 and never requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_ibus | input | 1 | Instruction-fetch bus error event pulse |
| ev_dbus | input | 1 | Data-access bus error event pulse |
| ev_cache | input | 1 | Cache error event pulse |
| ev_mchk | input | 1 | Machine check event pulse |
| dbg_entry | input | 1 | Debug exception taken, or exception while in debug mode |
| dbg_ret | input | 1 | Debug return executed |
| in_debug | input | 1 | Core is in debug mode |
| ack | input | 1 | Core took the exception currently requested |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | REG_W | Register write value |
| rd_data | output | REG_W | Register read value |
| exc_req | output | 4 | One-hot exception request |

## Verification
Every flag and the inhibit bit are registered, so any stimulus shows on `rd_data` one edge later. `exc_req` is decoded from that same state without a further register, so a request appears, moves or drops in the same cycle as the state that causes it. The driver applies each stimulus on a falling edge and queues the expected read value and request for the next rising edge. The monitor compares them two nanoseconds after that edge. This keeps every comparison exactly one state update behind its stimulus. Two instances are run side by side, one with all sources enabled and one with the default hard-wired sources.

// File: rtl/imperr_pkg.sv
package imperr_pkg;
   localparam int unsigned N_SRC      = 4;
   // source index: 0 data bus, 1 instruction bus, 2 cache, 3 machine check
   localparam int unsigned SRC_DBUS   = 0;
   localparam int unsigned SRC_IBUS   = 1;
   localparam int unsigned SRC_CACHE  = 2;
   localparam int unsigned SRC_MCHK   = 3;
   localparam int unsigned BIT_CNTDM  = 25;
   localparam int unsigned BIT_INH    = 20;
   localparam int unsigned SRC_BIT [N_SRC] = '{21, 24, 22, 23};
endpackage

// File: rtl/imperr_flag.sv
module imperr_flag #(
   parameter bit ENABLE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   logic set_eff;
   assign set_eff = set_i & ENABLE;

   // set wins over clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q_o <= 1'b0;
      else if (set_eff) q_o <= 1'b1;
      else if (clr_i)   q_o <= 1'b0;
   end
endmodule

// File: rtl/imperr_inhibit.sv
module imperr_inhibit (
   input  logic clk,
   input  logic rst_n,
   input  logic entry_i,
   input  logic ret_i,
   input  logic wr_i,
   input  logic wr_val_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q_o <= 1'b0;
      else if (entry_i) q_o <= 1'b1;
      else if (ret_i)   q_o <= 1'b0;
      else if (wr_i)    q_o <= wr_val_i;
   end
endmodule

// File: rtl/imperr_prio.sv
module imperr_prio #(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0] req_i,
   output logic [N-1:0] gnt_o
);
   // highest index has highest priority
   always_comb begin
      gnt_o = '0;
      for (int i = 0; i < int'(N); i++) begin
         if (req_i[i]) gnt_o = N'(1) << i;
      end
   end
endmodule

// File: rtl/imperr_pend_ctrl.sv
module imperr_pend_ctrl
   import imperr_pkg::*;
#(
   parameter int unsigned REG_W    = 32,
   parameter bit          EN_MCHK  = 1'b0,
   parameter bit          EN_CACHE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ev_ibus,
   input  logic             ev_dbus,
   input  logic             ev_cache,
   input  logic             ev_mchk,
   input  logic             dbg_entry,
   input  logic             dbg_ret,
   input  logic             in_debug,
   input  logic             ack,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   output logic [N_SRC-1:0] exc_req
);
   localparam logic [N_SRC-1:0] SRC_EN = {EN_MCHK, EN_CACHE, 1'b1, 1'b1};

   if (REG_W <= BIT_CNTDM) begin : g_bad_width
      $error("imperr_pend_ctrl: REG_W must exceed the highest field bit");
   end

   logic [N_SRC-1:0] ev_vec;
   logic [N_SRC-1:0] flag;
   logic [N_SRC-1:0] live;
   logic             inh;
   logic             unused_wr;

   assign ev_vec    = {ev_mchk, ev_cache, ev_ibus, ev_dbus};
   assign unused_wr = ^wr_data;

   for (genvar s = 0; s < int'(N_SRC); s++) begin : g_src
      logic wr_set;
      logic clr;
      assign wr_set = wr_en & wr_data[SRC_BIT[s]];
      assign clr    = ack & exc_req[s];
      imperr_flag #(.ENABLE(SRC_EN[s])) u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (ev_vec[s] | wr_set),
         .clr_i (clr),
         .q_o   (flag[s])
      );
   end

   imperr_inhibit u_inh (
      .clk      (clk),
      .rst_n    (rst_n),
      .entry_i  (dbg_entry),
      .ret_i    (dbg_ret),
      .wr_i     (wr_en & in_debug),
      .wr_val_i (wr_data[BIT_INH]),
      .q_o      (inh)
   );

   assign live = flag & {N_SRC{~inh}};

   imperr_prio #(.N(N_SRC)) u_prio (
      .req_i (live),
      .gnt_o (exc_req)
   );

   always_comb begin
      rd_data            = '0;
      rd_data[BIT_CNTDM] = 1'b1;
      rd_data[BIT_INH]   = inh;
      for (int s = 0; s < int'(N_SRC); s++) rd_data[SRC_BIT[s]] = flag[s];
   end
endmodule

// File: rtl/imperr_pend_chk.sv
module imperr_pend_chk
   import imperr_pkg::*;
#(
   parameter int unsigned REG_W    = 32,
   parameter bit          EN_MCHK  = 1'b0,
   parameter bit          EN_CACHE = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ev_ibus,
   input logic             ev_dbus,
   input logic             ev_mchk,
   input logic             dbg_entry,
   input logic             dbg_ret,
   input logic             in_debug,
   input logic             ack,
   input logic             wr_en,
   input logic [REG_W-1:0] rd_data,
   input logic [N_SRC-1:0] exc_req
);
   p_cntdm_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[BIT_CNTDM]);

   p_ibus_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ev_ibus |=> rd_data[SRC_BIT[SRC_IBUS]]);

   p_dbus_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ev_dbus |=> rd_data[SRC_BIT[SRC_DBUS]]);

   p_ibus_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[SRC_BIT[SRC_IBUS]] && !(ack && exc_req[SRC_IBUS]))
      |=> rd_data[SRC_BIT[SRC_IBUS]]);

   p_inhibit_gates_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[BIT_INH] |-> (exc_req == '0));

   p_onehot_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(exc_req));

   p_req_when_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_data[BIT_INH] && rd_data[SRC_BIT[SRC_DBUS]]) |-> (exc_req != '0));

   p_entry_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_entry |=> rd_data[BIT_INH]);

   p_ret_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_ret && !dbg_entry) |=> !rd_data[BIT_INH]);

   p_wr_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_debug && !dbg_entry && !dbg_ret) |=> $stable(rd_data[BIT_INH]));

   if (!EN_MCHK) begin : g_mchk_off
      p_mchk_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_data[SRC_BIT[SRC_MCHK]] && !exc_req[SRC_MCHK]);
   end else begin : g_mchk_on
      p_mchk_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
         ev_mchk |=> rd_data[SRC_BIT[SRC_MCHK]]);
   end

   if (!EN_CACHE) begin : g_cache_off
      p_cache_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_data[SRC_BIT[SRC_CACHE]] && !exc_req[SRC_CACHE]);
   end

   logic unused_chk;
   assign unused_chk = wr_en;
endmodule

bind imperr_pend_ctrl imperr_pend_chk #(
   .REG_W(REG_W), .EN_MCHK(EN_MCHK), .EN_CACHE(EN_CACHE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ev_ibus(ev_ibus), .ev_dbus(ev_dbus),
   .ev_mchk(ev_mchk), .dbg_entry(dbg_entry), .dbg_ret(dbg_ret),
   .in_debug(in_debug), .ack(ack), .wr_en(wr_en),
   .rd_data(rd_data), .exc_req(exc_req)
);

// File: tb/imperr_pend_ctrl_tb.sv
`timescale 1ns/1ps
module imperr_pend_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ev_ibus = 0, ev_dbus = 0, ev_cache = 0, ev_mchk = 0;
   logic        dbg_entry = 0, dbg_ret = 0, in_debug = 0, ack = 0, wr_en = 0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_a, rd_b;
   logic [3:0]  req_a, req_b;

   always #5 clk = ~clk;

   imperr_pend_ctrl #(.REG_W(32), .EN_MCHK(1'b1), .EN_CACHE(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .ev_ibus(ev_ibus), .ev_dbus(ev_dbus),
      .ev_cache(ev_cache), .ev_mchk(ev_mchk), .dbg_entry(dbg_entry),
      .dbg_ret(dbg_ret), .in_debug(in_debug), .ack(ack), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_a), .exc_req(req_a));

   imperr_pend_ctrl u_hw (
      .clk(clk), .rst_n(rst_n), .ev_ibus(ev_ibus), .ev_dbus(ev_dbus),
      .ev_cache(ev_cache), .ev_mchk(ev_mchk), .dbg_entry(dbg_entry),
      .dbg_ret(dbg_ret), .in_debug(in_debug), .ack(ack), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_b), .exc_req(req_b));

   typedef struct {
      logic [31:0] rd_a; logic [3:0] req_a;
      logic [31:0] rd_b; logic [3:0] req_b;
      string       tag;
   } item_t;

   item_t q[$];
   int checks = 0, failures = 0;
   bit done = 0;

   // model state, flags ordered {mchk, cache, ibus, dbus}
   logic [3:0] fa = '0, fb = '0;
   logic       inh = 1'b0;

   function automatic logic [3:0] pick(input logic [3:0] v);
      if (v[3]) return 4'b1000;
      if (v[2]) return 4'b0100;
      if (v[1]) return 4'b0010;
      if (v[0]) return 4'b0001;
      return 4'b0000;
   endfunction

   function automatic logic [31:0] pack(input logic [3:0] f, input logic i);
      return 32'h0200_0000 | (32'(f[1]) << 24) | (32'(f[3]) << 23)
           | (32'(f[2]) << 22) | (32'(f[0]) << 21) | (32'(i) << 20);
   endfunction

   task automatic step(input logic [3:0] ev, input logic ent, input logic ret,
                       input logic dbg, input logic ak, input logic we,
                       input logic [31:0] wd, input string tag);
      logic [3:0] set, ra, rb;
      item_t it;
      @(negedge clk);
      {ev_mchk, ev_cache, ev_ibus, ev_dbus} = ev;
      dbg_entry = ent; dbg_ret = ret; in_debug = dbg; ack = ak;
      wr_en = we; wr_data = wd;
      ra  = inh ? 4'b0 : pick(fa);
      rb  = inh ? 4'b0 : pick(fb);
      set = ev | (we ? {wd[23], wd[22], wd[24], wd[21]} : 4'b0);
      fa  = (set | (fa & ~(ak ? ra : 4'b0))) & 4'b1111;
      fb  = (set | (fb & ~(ak ? rb : 4'b0))) & 4'b0011;
      if (ent)             inh = 1'b1;
      else if (ret)        inh = 1'b0;
      else if (we && dbg)  inh = wd[20];
      it.rd_a  = pack(fa, inh);
      it.req_a = inh ? 4'b0 : pick(fa);
      it.rd_b  = pack(fb, inh);
      it.req_b = inh ? 4'b0 : pick(fb);
      it.tag   = tag;
      q.push_back(it);
   endtask

   task automatic cmp(input logic [31:0] act, input logic [31:0] exp,
                      input string what, input string tag);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // monitor: results are due one edge after the stimulus
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            cmp(rd_a, it.rd_a, "rd_data(all enabled)", it.tag);
            cmp({28'b0, req_a}, {28'b0, it.req_a}, "exc_req(all enabled)", it.tag);
            cmp(rd_b, it.rd_b, "rd_data(hard-wired)", it.tag);
            cmp({28'b0, req_b}, {28'b0, it.req_b}, "exc_req(hard-wired)", it.tag);
         end
      end
   end

   initial begin
      #2_000_000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      step(4'b0000, 0, 0, 0, 0, 0, '0, "R1 reset state");
      step(4'b0010, 0, 0, 0, 0, 0, '0, "R3 ibus event");
      step(4'b0001, 0, 0, 0, 0, 0, '0, "R3 dbus event, R7 ibus over dbus");
      step(4'b0000, 0, 0, 0, 1, 0, '0, "R5 ack clears ibus");
      step(4'b0000, 0, 0, 0, 0, 1, 32'h00C0_0000, "R4 R10 write sets mchk/cache");
      step(4'b0000, 0, 0, 0, 0, 1, 32'h0000_0000, "R4 write 0 no effect");
      step(4'b0100, 0, 0, 0, 0, 0, '0, "R10 cache event");
      step(4'b0000, 0, 0, 0, 1, 0, '0, "R7 R5 ack mchk first");
      step(4'b0000, 0, 0, 0, 1, 0, '0, "R7 R5 ack cache next");
      step(4'b0000, 0, 0, 0, 1, 0, '0, "R5 ack dbus last");
      step(4'b0000, 0, 0, 0, 1, 0, '0, "R5 ack without request");
      step(4'b0000, 1, 0, 0, 0, 0, '0, "R8 entry sets inhibit");
      step(4'b1111, 0, 0, 1, 0, 0, '0, "R6 events while inhibited");
      step(4'b0000, 0, 0, 1, 1, 0, '0, "R6 ack while inhibited");
      step(4'b0000, 0, 0, 0, 0, 1, 32'h0000_0000, "R9 inhibit write outside debug");
      step(4'b0000, 0, 0, 1, 0, 1, 32'h0000_0000, "R9 inhibit write in debug");
      step(4'b1000, 0, 0, 0, 1, 0, '0, "R5 event beats ack");
      step(4'b0000, 0, 0, 0, 1, 0, '0, "R5 ack mchk");
      step(4'b0000, 1, 1, 1, 0, 0, '0, "R8 entry beats return");
      step(4'b0000, 0, 1, 1, 0, 1, 32'h0010_0000, "R8 return beats write");
      step(4'b0000, 0, 0, 1, 0, 1, 32'h0010_0000, "R9 inhibit set by write");
      step(4'b0000, 0, 0, 1, 0, 1, 32'hFFFF_FFFF, "R2 all-ones write");
      step(4'b0000, 0, 1, 0, 0, 0, '0, "R2 R7 after return");
      step(4'b0000, 0, 0, 0, 0, 0, '0, "R7 idle");
      @(negedge clk);
      {ev_mchk, ev_cache, ev_ibus, ev_dbus} = '0;
      dbg_entry = 0; dbg_ret = 0; in_debug = 0; ack = 0; wr_en = 0; wr_data = '0;
      while (q.size() > 0) @(posedge clk);
      repeat (2) @(posedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule